// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim/Complete

This block gathers a set of external interrupt lines and routes them to several target contexts, each of which sees one interrupt request output. Every source passes through a gateway that turns a level-high or rising-edge request into a pending bit. It then holds off further requests from that source until the handler reports that it is done. Each context has its own set of enable bits and its own priority threshold. Its request output is high while at least one source is pending, enabled for that context and strictly above its threshold.

Software services a context in two steps. It first reads the context's claim register, which returns the best eligible source ID and clears that source's pending bit. Once the handler is done, software writes the same ID back to the claim register, which reopens the gateway. Register access is a single-cycle port with 32-bit data and byte addresses. Writes take effect at the clock edge. Read data appears on `rdata_o` after the edge that accepts the read and is held until the next read.

Top module: `plic_top`

## Requirements
- R1: Source ID 0 does not exist: its priority word (offset 0x0) and its pending and enable bits (bit 0 of the first word) read 0, a completion with ID 0 has no effect, and a claim read returns 0 when no source is eligible.
- R2: Source ID n has a priority register at byte offset 4*n, holding the low 3 bits of the written word and reading back zero-extended. Priority 0 never interrupts.
- R3: Pending bits are read-only, packed 32 per word from offset 0x1000: source n is word n/32, bit n%32. A level source becomes pending the cycle after its line is sampled high while its gateway is idle.
- R4: Context c has its enable words at 0x2000 + 0x80*c with the same bit mapping as the pending bits. Bits of absent sources read 0.
- R5: Context c has its threshold at 0x200000 + 0x1000*c (3 bits) and its claim/complete register at that base + 0x4. irq_o[c] is high exactly when some source is pending, enabled for c and has a priority strictly greater than the threshold. Threshold 7 blocks every source.
- R6: Among the eligible sources, the claim returns the one with the highest priority. Ties go to the lowest ID.
- R7: A claim read returns the winning ID and clears its pending bit. Sources that are pending but disabled or at priority 0 stay pending and are not returned.
- R8: In level mode, a claimed source cannot become pending again before it is completed. After completion, a line that is still high makes it pending again.
- R9: The trigger words at 0x1080 use the pending bit mapping: bit = 1 selects rising edge, 0 selects level high. In edge mode a rising edge sets pending. At most one edge that arrives between claim and complete is kept, and it sets pending at completion. Further edges in that window are dropped.
- R10: A completion write is ignored if its ID is 0, greater than the number of sources, or not enabled for the context being written.
- R11: Reset clears every register, pending bit, rdata_o and irq_o. Reads of unimplemented offsets return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | NUM_SRC | Interrupt lines, bit n is source ID n (IDs 1..NUM_SRC) |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid after the accepting edge |
| irq_o | output | NUM_CTX | Interrupt request per context |

## Verification
The bench uses the default build: 40 sources, two contexts and a 3-bit priority. Forty sources spread the pending, enable and trigger arrays across two words, so IDs 32 to 40 test the word/bit split and the masking of the unused upper bits. Two contexts let the bench check that enables, thresholds and completions stay local to one context, for example a completion sent to the wrong context or a threshold of 7 on one context while the other still fires.

// File: rtl/plic_pkg.sv
package plic_pkg;
  localparam int unsigned PRIO_BASE  = 32'h0;
  localparam int unsigned PEND_BASE  = 32'h1000;
  localparam int unsigned TRIG_BASE  = 32'h1080;
  localparam int unsigned EN_BASE    = 32'h2000;
  localparam int unsigned EN_STRIDE  = 32'h80;
  localparam int unsigned CTX_BASE   = 32'h200000;
  localparam int unsigned CTX_STRIDE = 32'h1000;
  localparam int unsigned THR_OFS    = 32'h0;
  localparam int unsigned CLAIM_OFS  = 32'h4;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;
endpackage

// File: rtl/plic_gateway.sv
module plic_gateway
  import plic_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic mode_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o
);
  logic irq_q, pending_q, busy_q, saved_q;
  logic is_edge, req;

  assign is_edge   = (trig_e'(mode_i) == TRIG_EDGE);
  assign req       = is_edge ? (irq_i & ~irq_q) : irq_i;
  assign pending_o = pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q     <= 1'b0;
      pending_q <= 1'b0;
      busy_q    <= 1'b0;
      saved_q   <= 1'b0;
    end else begin
      irq_q <= irq_i;
      if (claim_i) begin
        pending_q <= 1'b0;
        busy_q    <= 1'b1;
        saved_q   <= is_edge & req;
      end else if (complete_i && busy_q) begin
        busy_q    <= 1'b0;
        pending_q <= is_edge & (saved_q | req);
        saved_q   <= 1'b0;
      end else if (req) begin
        if (!busy_q) pending_q <= 1'b1;
        else if (is_edge) saved_q <= 1'b1;
      end
    end
  end

  // R8: a source in service is never pending
  a_r8_busy_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !pending_q);
  // R7: a claim always clears pending
  a_r7_claim_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_i |=> !pending_o);
  // R9: a stored edge exists only while in service
  a_r9_saved_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    saved_q |-> busy_q);
endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter #(
  parameter int NUM_SRC = 40,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SRC:0]              pend_i,
  input  logic [NUM_SRC:0]              en_i,
  input  logic [NUM_SRC:0][PRIO_W-1:0]  prio_i,
  input  logic [PRIO_W-1:0]             thr_i,
  output logic [ID_W-1:0]               id_o,
  output logic                          irq_o
);
  logic [PRIO_W-1:0] best;

  // strict compare keeps the lowest ID on a tie
  always_comb begin
    id_o = '0;
    best = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (pend_i[i] && en_i[i] && (prio_i[i] > thr_i) && (prio_i[i] > best)) begin
        best = prio_i[i];
        id_o = ID_W'(i);
      end
    end
  end

  assign irq_o = (id_o != '0);

  // R5: a reported winner satisfies every eligibility condition
  a_r5_winner_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_o != '0) |-> (pend_i[id_o] && en_i[id_o] && (prio_i[id_o] > thr_i)));
  // R5: the top threshold blocks everything
  a_r5_thr_max_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_i == '1) |-> !irq_o);
endmodule

// File: rtl/plic_top.sv
module plic_top
  import plic_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 26
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC:1]   irq_src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic [NUM_CTX-1:0] irq_o
);
  localparam int NUM_ID = NUM_SRC + 1;
  localparam int NWORDS = (NUM_ID + 31) / 32;
  localparam int NBITS  = NWORDS * 32;
  localparam int ID_W   = $clog2(NUM_ID);
  localparam logic [NBITS-1:0] SRC_MASK = ((NBITS'(1) << NUM_ID) - NBITS'(1)) & ~NBITS'(1);

  logic [NUM_SRC:0][PRIO_W-1:0]    prio_q;
  logic [NBITS-1:0]                trig_q;
  logic [NUM_CTX-1:0][NBITS-1:0]   en_q;
  logic [NUM_CTX-1:0][PRIO_W-1:0]  thr_q;
  logic [NBITS-1:0]                pend_vec;
  logic [NUM_CTX-1:0][ID_W-1:0]    best_id;

  logic [NUM_SRC:0]                prio_hit;
  logic [NWORDS-1:0]               trig_hit;
  logic [NUM_CTX-1:0][NWORDS-1:0]  en_hit;
  logic [NUM_CTX-1:0]              thr_hit, claim_hit;
  logic [31:0]                     rd_val;
  logic [NUM_SRC:0]                claim_vec, cmpl_vec;
  logic                            wr, rd, cmpl_ok;
  logic [ID_W-1:0]                 cmpl_id;

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign cmpl_ok = (wdata_i != 32'd0) && (wdata_i <= 32'(NUM_SRC));
  assign cmpl_id = wdata_i[ID_W-1:0];

  // flat address match, one comparator per implemented word
  always_comb begin
    rd_val    = '0;
    prio_hit  = '0;
    trig_hit  = '0;
    en_hit    = '0;
    thr_hit   = '0;
    claim_hit = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (addr_i == ADDR_W'(PRIO_BASE + 4 * i)) begin
        rd_val      = 32'(prio_q[i]);
        prio_hit[i] = 1'b1;
      end
    end
    for (int w = 0; w < NWORDS; w++) begin
      if (addr_i == ADDR_W'(PEND_BASE + 4 * w)) rd_val = pend_vec[w*32 +: 32];
      if (addr_i == ADDR_W'(TRIG_BASE + 4 * w)) begin
        rd_val      = trig_q[w*32 +: 32];
        trig_hit[w] = 1'b1;
      end
    end
    for (int c = 0; c < NUM_CTX; c++) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (addr_i == ADDR_W'(EN_BASE + EN_STRIDE * c + 4 * w)) begin
          rd_val       = en_q[c][w*32 +: 32];
          en_hit[c][w] = 1'b1;
        end
      end
      if (addr_i == ADDR_W'(CTX_BASE + CTX_STRIDE * c + THR_OFS)) begin
        rd_val     = 32'(thr_q[c]);
        thr_hit[c] = 1'b1;
      end
      if (addr_i == ADDR_W'(CTX_BASE + CTX_STRIDE * c + CLAIM_OFS)) begin
        rd_val       = 32'(best_id[c]);
        claim_hit[c] = 1'b1;
      end
    end
  end

  always_comb begin
    claim_vec = '0;
    cmpl_vec  = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (rd && claim_hit[c] && (best_id[c] != '0)) claim_vec[best_id[c]] = 1'b1;
      if (wr && claim_hit[c] && cmpl_ok && en_q[c][cmpl_id]) cmpl_vec[cmpl_id] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q  <= '0;
      trig_q  <= '0;
      en_q    <= '0;
      thr_q   <= '0;
      rdata_o <= '0;
    end else begin
      if (rd) rdata_o <= rd_val;
      if (wr) begin
        for (int i = 1; i <= NUM_SRC; i++)
          if (prio_hit[i]) prio_q[i] <= wdata_i[PRIO_W-1:0];
        for (int w = 0; w < NWORDS; w++)
          if (trig_hit[w]) trig_q[w*32 +: 32] <= wdata_i & SRC_MASK[w*32 +: 32];
        for (int c = 0; c < NUM_CTX; c++) begin
          for (int w = 0; w < NWORDS; w++)
            if (en_hit[c][w]) en_q[c][w*32 +: 32] <= wdata_i & SRC_MASK[w*32 +: 32];
          if (thr_hit[c]) thr_q[c] <= wdata_i[PRIO_W-1:0];
        end
      end
    end
  end

  assign pend_vec[0] = 1'b0;
  if (NBITS > NUM_ID) begin : g_pend_pad
    assign pend_vec[NBITS-1:NUM_ID] = '0;
  end

  for (genvar i = 1; i <= NUM_SRC; i++) begin : g_gw
    plic_gateway u_gw (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .irq_i      (irq_src_i[i]),
      .mode_i     (trig_q[i]),
      .claim_i    (claim_vec[i]),
      .complete_i (cmpl_vec[i]),
      .pending_o  (pend_vec[i])
    );
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    plic_arbiter #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .ID_W    (ID_W)
    ) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pend_i (pend_vec[NUM_SRC:0]),
      .en_i   (en_q[c][NUM_SRC:0]),
      .prio_i (prio_q),
      .thr_i  (thr_q[c]),
      .id_o   (best_id[c]),
      .irq_o  (irq_o[c])
    );
  end

  // R7: at most one source claimed per access, and only by a read
  a_r7_single_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(claim_vec));
  a_r7_claim_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_vec != '0) |-> (req_i && !we_i));
  // R11: read data only moves on a read
  a_r11_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
endmodule

// File: tb/plic_top_test.sv
`timescale 1ns/1ps
module plic_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [40:1] irq = '0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [25:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq_out;
  int          n_cmp = 0;
  int          n_bad = 0;

  localparam logic [25:0] P0 = 26'h1000, P1 = 26'h1004;
  localparam logic [25:0] THR0 = 26'h200000, CLM0 = 26'h200004;
  localparam logic [25:0] THR1 = 26'h201000, CLM1 = 26'h201004;

  always #2 clk = ~clk;

  plic_top uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .irq_src_i (irq),
    .req_i     (req),
    .we_i      (we),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .irq_o     (irq_out)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [25:0] waddr;
    logic [31:0] wdat;
    logic [25:0] raddr;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{4'd2,  26'h14,     32'h3,        26'h14,     32'h3},        // R2
    '{4'd2,  26'h14,     32'hFF,       26'h14,     32'h7},        // R2 3-bit field
    '{4'd1,  26'h0,      32'h5,        26'h0,      32'h0},        // R1 no source 0
    '{4'd1,  26'h2000,   32'hFFFFFFFF, 26'h2000,   32'hFFFFFFFE}, // R1 enable bit 0
    '{4'd4,  26'h2004,   32'hFFFFFFFF, 26'h2004,   32'h1FF},      // R4 ids 32..40
    '{4'd4,  26'h2080,   32'hF0,       26'h2080,   32'hF0},       // R4 context 1
    '{4'd5,  26'h201000, 32'hF,        26'h201000, 32'h7},        // R5 threshold
    '{4'd3,  26'h1000,   32'hFFFFFFFF, 26'h1000,   32'h0},        // R3 read-only
    '{4'd11, 26'h1234,   32'hFFFFFFFF, 26'h1234,   32'h0},        // R11 hole
    '{4'd9,  26'h1084,   32'hFFFFFFFF, 26'h1084,   32'h1FF},      // R9 trigger word
    '{4'd2,  26'hA0,     32'h6,        26'hA0,     32'h6},        // R2 last id
    '{4'd11, 26'hA4,     32'h6,        26'hA4,     32'h0},        // R11 beyond last id
    '{4'd1,  26'h200004, 32'h0,        26'h200004, 32'h0}         // R1 nothing eligible
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [25:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [25:0] a, output logic [31:0] v);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    v = rdata;
  endtask

  task automatic pulse(input int id);
    irq[id] = 1'b1;
    @(negedge clk);
    irq[id] = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R11 reset rdata", rdata, 32'h0);
    chk("R11 reset irq", 32'(irq_out), 32'h0);

    for (int k = 0; k < NVEC; k++) begin
      wr(VECS[k].waddr, VECS[k].wdat);
      rd(VECS[k].raddr, v);
      chk($sformatf("R%0d table entry %0d", VECS[k].rq, k), v, VECS[k].exp);
    end

    // fresh state for directed tests
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    rd(26'h14, v);   chk("R11 prio after reset", v, 32'h0);
    rd(26'h2000, v); chk("R11 enable after reset", v, 32'h0);

    wr(26'h0C, 2); wr(26'h1C, 5); wr(26'h24, 5); wr(26'h8C, 1);
    wr(26'h2000, 32'h288); wr(26'h2004, 32'h8);

    irq[3] = 1'b1; idle(1);
    rd(P0, v); chk("R3 pending id3", v, 32'h8);
    chk("R5 irq ctx0 only", 32'(irq_out), 32'h1);
    wr(THR0, 2); chk("R5 strict threshold", 32'(irq_out), 32'h0);
    wr(THR0, 1); chk("R5 below threshold fires", 32'(irq_out), 32'h1);
    wr(THR0, 0);

    irq[7] = 1'b1; irq[9] = 1'b1; irq[35] = 1'b1; idle(1);
    rd(P1, v);   chk("R3 pending id35 word1", v, 32'h8);
    rd(CLM0, v); chk("R6 highest prio lowest id", v, 32'd7);
    rd(P0, v);   chk("R7 claim clears, R8 held", v, 32'h208);
    rd(CLM0, v); chk("R6 tie second", v, 32'd9);
    rd(CLM0, v); chk("R6 next priority", v, 32'd3);
    rd(CLM0, v); chk("R6 lowest priority", v, 32'd35);
    rd(CLM0, v); chk("R1 claim empty", v, 32'd0);
    chk("R5 irq low after claims", 32'(irq_out), 32'h0);

    wr(CLM0, 7); idle(1);
    rd(P0, v);   chk("R8 level repends after complete", v, 32'h80);
    rd(CLM0, v); chk("R8 reclaim", v, 32'd7);
    irq[3] = 1'b0; irq[7] = 1'b0; irq[9] = 1'b0; irq[35] = 1'b0;
    wr(CLM0, 7); wr(CLM0, 9); wr(CLM0, 3); wr(CLM0, 35); idle(1);
    rd(P0, v); chk("R8 line low stays idle w0", v, 32'h0);
    rd(P1, v); chk("R8 line low stays idle w1", v, 32'h0);

    irq[9] = 1'b1; idle(1);
    rd(CLM0, v); chk("R10 claim id9", v, 32'd9);
    wr(CLM1, 9); idle(1);
    rd(P0, v); chk("R10 wrong context ignored", v, 32'h0);
    wr(CLM0, 50); wr(CLM0, 0); idle(1);
    rd(P0, v); chk("R10 out of range ignored", v, 32'h0);
    wr(CLM0, 9); idle(1);
    rd(P0, v); chk("R10 valid completion", v, 32'h200);
    irq[9] = 1'b0;
    rd(CLM0, v); chk("R7 claim id9", v, 32'd9);
    wr(CLM0, 9); idle(1);

    irq[20] = 1'b1; idle(1); irq[20] = 1'b0;
    rd(P0, v);   chk("R7 disabled pending", v, 32'h100000);
    rd(CLM0, v); chk("R7 disabled not claimed", v, 32'd0);
    rd(P0, v);   chk("R7 disabled stays pending", v, 32'h100000);

    wr(26'h1084, 32'h10); wr(26'h90, 4); wr(26'h2004, 32'h18);
    pulse(36);
    rd(P1, v);   chk("R9 edge sets pending", v, 32'h10);
    chk("R9 edge raises irq", 32'(irq_out), 32'h1);
    rd(CLM0, v); chk("R9 claim edge source", v, 32'd36);
    rd(P1, v);   chk("R9 cleared by claim", v, 32'h0);
    pulse(36); pulse(36);
    rd(P1, v);   chk("R9 blocked in service", v, 32'h0);
    wr(CLM0, 36); idle(1);
    rd(P1, v);   chk("R9 saved edge released", v, 32'h10);
    rd(CLM0, v); chk("R9 claim saved edge", v, 32'd36);
    wr(CLM0, 36); idle(1);
    rd(P1, v);   chk("R9 extra edge dropped", v, 32'h0);

    wr(26'h2080, 32'h8); wr(THR1, 7);
    irq[3] = 1'b1; idle(1);
    chk("R5 threshold 7 blocks ctx1", 32'(irq_out), 32'h1);
    wr(THR1, 1);
    chk("R5 both contexts", 32'(irq_out), 32'h3);
    rd(CLM1, v); chk("R5 claim from ctx1", v, 32'd3);
    chk("R5 both low after claim", 32'(irq_out), 32'h0);
    irq[3] = 1'b0;
    wr(CLM1, 3); idle(1);
    rd(P0, v); chk("R10 ctx1 completion", v, 32'h100000);

    rd(26'h2100, v);   chk("R11 absent context enable", v, 32'h0);
    rd(26'h202000, v); chk("R11 absent context block", v, 32'h0);
    rd(26'h1008, v);   chk("R11 pending beyond last word", v, 32'h0);

    summary();
    $finish;
  end
endmodule